// File: doc/BRIEF.md
# Microsequencer with Segmented Control Store

This block sequences a microcoded processor. An opcode register and a 4-bit step counter together form the control-store address. Each opcode owns a fixed segment of 16 words. Each word is a 32-bit control word that drives the datapath. Segment 0 holds the fetch routine. When that routine asserts the instruction-load bit, the fetched instruction is reduced to a 9-bit key. The key indexes a decode table, and the table returns the segment number for the next instruction. A word that asserts the finish bit sends the sequencer back to fetch.

The block also decides whether the program counter is written. A word with the compare bit set captures equality, signed less-than and unsigned less-than of the two ALU operands. A later word's 3-bit branch condition is tested against those captured flags. The control store and the decode table are filled through write ports while the block is held in reset.

Top module: `useq_core`

## Requirements
- R1: While reset is active and in the first cycle after it, `ucode_addr` is 0 and `pc_we` is 0.
- R2: `ctrl_word` is the control-store word at address {opcode, step}, with the opcode in bits 9:4 and the step in bits 3:0, as written through the control-store port.
- R3: If a word has neither bit 0 nor bit 21 set, the step advances by one in the next cycle and the opcode is unchanged. Step 15 wraps to step 0 of the same segment.
- R4: A word with bit 21 set loads the opcode from the decode table and clears the step, so the next cycle executes step 0 of the new segment.
- R5: The decode key is {instr[30], instr[14:12], instr[6:2]}. All other instruction bits have no effect on the loaded opcode.
- R6: A word with bit 0 set makes the next address 0, which is step 0 of fetch. Bit 0 has priority over bit 21 in the same word.
- R7: A word with bit 7 set captures, for the following cycles, whether `cmp_a` equals `cmp_b`, whether it is smaller as a signed number, and whether it is smaller as an unsigned number. Reset clears all three flags.
- R8: `pc_we` follows bits 5:3 of the current word: 0 never, 1 always, 2 equal, 3 signed less, 4 unsigned less, 5 not equal, 6 signed greater-or-equal, 7 unsigned greater-or-equal.
- R9: If a word both sets bit 7 and carries a condition, the condition is tested against the flags captured earlier, not the ones being captured.
- R10: The field outputs follow the current word: `reg_we` is bit 1, `reg_re` is bit 2, `pc_re` is bit 6, `imm_sel` is bits 24:22, `imm_en` is bit 25 and `reg_sel` is bits 31:30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_we | input | 1 | Control-store write enable |
| cs_waddr | input | 10 | Control-store write address {opcode, step} |
| cs_wdata | input | 32 | Control-store write data |
| dec_we | input | 1 | Decode-table write enable |
| dec_waddr | input | 9 | Decode-table write key |
| dec_wdata | input | 6 | Segment number stored for that key |
| instr | input | 32 | Fetched instruction word |
| cmp_a | input | 32 | First ALU operand |
| cmp_b | input | 32 | Second ALU operand |
| ctrl_word | output | 32 | Current control word |
| ucode_addr | output | 10 | Current control-store address |
| pc_we | output | 1 | Resolved program-counter write |
| reg_we | output | 1 | Register write field |
| reg_re | output | 1 | Register read field |
| pc_re | output | 1 | PC read field |
| imm_en | output | 1 | Immediate enable field |
| imm_sel | output | 3 | Immediate format field |
| reg_sel | output | 2 | Register select field |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is capturing a comparison and testing a condition. One segment sets the compare bit together with an equality test. It runs directly after another segment has captured an "equal" result, and with operands that now differ. The bench then expects the write to fire on the old flags in that word and to stay low on the new flags in the word after it. The second pair is the finish bit and the load bit in one word. The bench judges that case by whether the next address is 0 or the decoded segment.

// File: rtl/useq_core.sv
`timescale 1ns/1ps
module useq_core #(
  parameter int OPC_W  = 6,
  parameter int STEP_W = 4,
  parameter int CW_W   = 32,
  parameter int XLEN   = 32,
  parameter int IW     = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_we,
  input  logic [OPC_W+STEP_W-1:0]  cs_waddr,
  input  logic [CW_W-1:0]          cs_wdata,
  input  logic                     dec_we,
  input  logic [8:0]               dec_waddr,
  input  logic [OPC_W-1:0]         dec_wdata,
  input  logic [IW-1:0]            instr,
  input  logic [XLEN-1:0]          cmp_a,
  input  logic [XLEN-1:0]          cmp_b,
  output logic [CW_W-1:0]          ctrl_word,
  output logic [OPC_W+STEP_W-1:0]  ucode_addr,
  output logic                     pc_we,
  output logic                     reg_we,
  output logic                     reg_re,
  output logic                     pc_re,
  output logic                     imm_en,
  output logic [2:0]               imm_sel,
  output logic [1:0]               reg_sel
);
  localparam int ADDR_W = OPC_W + STEP_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int KEY_W  = 9;
  localparam int KDEPTH = 1 << KEY_W;
  localparam int B_FIN  = 0;
  localparam int B_RWE  = 1;
  localparam int B_RRE  = 2;
  localparam int B_PCC  = 3;
  localparam int B_PCR  = 6;
  localparam int B_CMP  = 7;
  localparam int B_LDI  = 21;
  localparam int B_IMS  = 22;
  localparam int B_IME  = 25;
  localparam int B_RSS  = 30;

  logic [CW_W-1:0]   store [DEPTH];
  logic [OPC_W-1:0]  dtab  [KDEPTH];
  logic [OPC_W-1:0]  opc;
  logic [STEP_W-1:0] step;
  logic              f_eq, f_lt, f_ltu;
  logic [KEY_W-1:0]  key;
  logic [2:0]        cond;
  logic              unused_instr_bits;

  always_ff @(posedge clk) begin
    if (cs_we) store[cs_waddr] <= cs_wdata;
    if (dec_we) dtab[dec_waddr] <= dec_wdata;
  end

  assign ucode_addr = {opc, step};
  assign ctrl_word  = store[ucode_addr];
  assign key        = {instr[30], instr[14:12], instr[6:2]};
  assign unused_instr_bits = ^{instr[31], instr[29:15], instr[11:7], instr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc  <= '0;
      step <= '0;
    end else if (ctrl_word[B_FIN]) begin
      opc  <= '0;
      step <= '0;
    end else if (ctrl_word[B_LDI]) begin
      opc  <= dtab[key];
      step <= '0;
    end else begin
      step <= step + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_eq  <= 1'b0;
      f_lt  <= 1'b0;
      f_ltu <= 1'b0;
    end else if (ctrl_word[B_CMP]) begin
      f_eq  <= cmp_a == cmp_b;
      f_lt  <= $signed(cmp_a) < $signed(cmp_b);
      f_ltu <= cmp_a < cmp_b;
    end
  end

  assign cond = ctrl_word[B_PCC +: 3];

  always_comb begin
    case (cond)
      3'd0:    pc_we = 1'b0;
      3'd1:    pc_we = 1'b1;
      3'd2:    pc_we = f_eq;
      3'd3:    pc_we = f_lt;
      3'd4:    pc_we = f_ltu;
      3'd5:    pc_we = !f_eq;
      3'd6:    pc_we = !f_lt;
      default: pc_we = !f_ltu;
    endcase
  end

  assign reg_we  = ctrl_word[B_RWE];
  assign reg_re  = ctrl_word[B_RRE];
  assign pc_re   = ctrl_word[B_PCR];
  assign imm_en  = ctrl_word[B_IME];
  assign imm_sel = ctrl_word[B_IMS +: 3];
  assign reg_sel = ctrl_word[B_RSS +: 2];
endmodule

module useq_core_chk #(
  parameter int ADDR_W = 10,
  parameter int STEP_W = 4,
  parameter int CW_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW_W-1:0]   ctrl_word,
  input logic [ADDR_W-1:0] ucode_addr,
  input logic              pc_we
);
  AST_FINISH_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[0] |=> ucode_addr == '0); // R6
  AST_LOAD_CLEARS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[21] |=> ucode_addr[STEP_W-1:0] == '0); // R4
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_word[0] && !ctrl_word[21]) |=>
      (ucode_addr[ADDR_W-1:STEP_W] == $past(ucode_addr[ADDR_W-1:STEP_W]) &&
       ucode_addr[STEP_W-1:0] == STEP_W'($past(ucode_addr[STEP_W-1:0]) + 1'b1))); // R3
  AST_NEVER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[5:3] == 3'd0 |-> !pc_we); // R8
  AST_ALWAYS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[5:3] == 3'd1 |-> pc_we); // R8
endmodule

bind useq_core useq_core_chk #(.ADDR_W(OPC_W + STEP_W), .STEP_W(STEP_W), .CW_W(CW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ucode_addr(ucode_addr), .pc_we(pc_we));

// File: tb/useq_core_bench.sv
`timescale 1ns/1ps
module useq_core_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cs_we = 0;
  logic [9:0]  cs_waddr = 0;
  logic [31:0] cs_wdata = 0;
  logic        dec_we = 0;
  logic [8:0]  dec_waddr = 0;
  logic [5:0]  dec_wdata = 0;
  logic [31:0] instr = 0, cmp_a = 0, cmp_b = 0;
  logic [31:0] ctrl_word;
  logic [9:0]  ucode_addr;
  logic        pc_we, reg_we, reg_re, pc_re, imm_en;
  logic [2:0]  imm_sel;
  logic [1:0]  reg_sel;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_eq = 0, m_lt = 0, m_ltu = 0;

  always #4 clk = ~clk;

  useq_core u_useq_core (
    .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cs_waddr(cs_waddr), .cs_wdata(cs_wdata),
    .dec_we(dec_we), .dec_waddr(dec_waddr), .dec_wdata(dec_wdata), .instr(instr),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .ctrl_word(ctrl_word), .ucode_addr(ucode_addr),
    .pc_we(pc_we), .reg_we(reg_we), .reg_re(reg_re), .pc_re(pc_re), .imm_en(imm_en),
    .imm_sel(imm_sel), .reg_sel(reg_sel));

  function automatic logic [31:0] flow(int op, int s);
    if (op == 0) return (s == 2) ? 32'h0020_0000 : 32'h0;
    if (op >= 1 && op <= 15) return (s == op - 1) ? 32'h1 : 32'h0;
    if (op >= 40 && op <= 47) begin
      if (s == 0) return 32'h80;
      if (s == 1) return 32'(op - 40) << 3;
      if (s == 2) return 32'h1;
      return 32'h0;
    end
    if (op == 50) return (s == 0) ? 32'h90 : (s == 1) ? 32'h11 : 32'h0;
    if (op == 51) return (s == 0) ? 32'h80 : (s == 1) ? 32'h1 : 32'h0;
    if (op == 52) return (s == 0) ? 32'h0020_0001 : 32'h0;
    return 32'h0;
  endfunction

  function automatic logic [31:0] expw(int a);
    logic [31:0] r;
    r = (32'(a) * 32'h9E37_79B9) ^ (32'(a) << 13);
    return (r & 32'hFFDF_FF46) | flow(a >> 4, a & 15);
  endfunction

  function automatic int dmap(int k);
    if ((k >= 1 && k <= 15) || k == 20 || (k >= 40 && k <= 47) || (k >= 50 && k <= 52)) return k;
    if (k == 9'h1A5) return 7;
    return -1;
  endfunction

  function automatic logic [31:0] mk_instr(logic [8:0] key, logic [31:0] g);
    logic [31:0] i;
    i = g;
    i[6:2] = key[4:0];
    i[14:12] = key[7:5];
    i[30] = key[8];
    return i;
  endfunction

  function automatic bit cond_of(logic [2:0] c);
    case (c)
      3'd0: return 0;
      3'd1: return 1;
      3'd2: return m_eq;
      3'd3: return m_lt;
      3'd4: return m_ltu;
      3'd5: return !m_eq;
      3'd6: return !m_lt;
      default: return !m_ltu;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_check(input int op, input int s, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] w;
    string req;
    w = expw(op * 16 + s);
    chk(ucode_addr == 10'(op * 16 + s), "R3", 64'(ucode_addr), 64'(op * 16 + s));
    chk(ctrl_word == w, "R2", 64'(ctrl_word), 64'(w));
    chk({reg_sel, imm_en, imm_sel, pc_re, reg_re, reg_we} == {w[31:30], w[25], w[24:22], w[6], w[2], w[1]},
        "R10", 64'({reg_sel, imm_en, imm_sel, pc_re, reg_re, reg_we}),
        64'({w[31:30], w[25], w[24:22], w[6], w[2], w[1]}));
    if (w[7] && w[5:3] != 0) req = "R9";
    else if (w[5:3] > 1) req = "R7";
    else req = "R8";
    chk(pc_we == cond_of(w[5:3]), req, 64'(pc_we), 64'(cond_of(w[5:3])));
    if (w[7]) begin
      m_eq = (a == b);
      m_lt = ($signed(a) < $signed(b));
      m_ltu = (a < b);
    end
    @(negedge clk);
  endtask

  task automatic fetch(input logic [8:0] key, input logic [31:0] g, input logic [31:0] a, input logic [31:0] b);
    instr = mk_instr(key, g);
    cmp_a = a;
    cmp_b = b;
    for (int s = 0; s < 3; s++) step_check(0, s, a, b);
  endtask

  task automatic go(input logic [8:0] key, input logic [31:0] g, input int op, input int len,
                    input logic [31:0] a, input logic [31:0] b);
    fetch(key, g, a, b);
    chk(ucode_addr == 10'(op * 16), "R4", 64'(ucode_addr), 64'(op * 16));
    for (int s = 0; s < len; s++) step_check(op, s, a, b);
    chk(ucode_addr == 10'd0, "R6", 64'(ucode_addr), 64'd0);
  endtask

  initial begin
    logic [31:0] vals [6];
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h5;
    @(negedge clk);
    for (int a = 0; a < 1024; a++) begin
      cs_we = 1; cs_waddr = 10'(a); cs_wdata = expw(a);
      @(negedge clk);
    end
    cs_we = 0;
    for (int k = 0; k < 512; k++) begin
      if (dmap(k) >= 0) begin
        dec_we = 1; dec_waddr = 9'(k); dec_wdata = 6'(dmap(k));
        @(negedge clk);
      end
    end
    dec_we = 0;
    chk(ucode_addr == 0 && pc_we == 0, "R1", 64'({ucode_addr, pc_we}), 64'd0);
    rst_n = 1;
    chk(ucode_addr == 0 && pc_we == 0, "R1", 64'({ucode_addr, pc_we}), 64'd0);

    for (int k = 1; k <= 15; k++) go(9'(k), 32'hA5A5_0000 ^ 32'(k * 7919), k, k, 0, 0);
    go(9'h1A5, 32'hFFFF_FFFF, 7, 7, 0, 0);   // R5 other key bits
    go(9'h007, 32'h0000_0000, 7, 7, 0, 0);   // R5
    go(9'h00C, 32'hBFFF_8F83, 12, 12, 0, 0); // R5 non-key bits all set

    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          go(9'(40 + c), 32'(c * 131 + i * 17 + j), 40 + c, 3, vals[i], vals[j]);

    go(9'd51, 32'h0, 51, 2, 32'd7, 32'd7);
    go(9'd50, 32'h0, 50, 2, 32'd3, 32'd9);   // R9 same-cycle latch and test

    fetch(9'd52, 32'h0, 0, 0);
    chk(ucode_addr == 10'(52 * 16), "R4", 64'(ucode_addr), 64'(52 * 16));
    @(negedge clk);
    chk(ucode_addr == 10'd0, "R6", 64'(ucode_addr), 64'd0); // finish beats load

    fetch(9'd20, 32'h1234_5678, 0, 0);
    for (int s = 0; s < 16; s++) step_check(20, s, 0, 0);
    chk(ucode_addr == 10'(20 * 16), "R3", 64'(ucode_addr), 64'(20 * 16)); // wrap

    rst_n = 0;
    m_eq = 0; m_lt = 0; m_ltu = 0;
    @(negedge clk);
    chk(ucode_addr == 0 && pc_we == 0, "R1", 64'({ucode_addr, pc_we}), 64'd0);
    rst_n = 1;
    go(9'd46, 32'h0, 46, 3, 32'd1, 32'd2); // R7 ge after fresh latch

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule